// File: doc/BRIEF.md
# Satellite Tone Modulation Controller

This block produces the 22 kHz signalling tone used on the supply line of a satellite antenna. It runs from a base clock at twenty times the tone frequency and delivers two signals to the analog output stage: a square-wave tone and a flag that says when the tone must be superimposed on the DC output. The tone is produced by dividing the base clock by twenty.

Three source modes are selected by two register bits and one external modulation input. A force bit makes the tone continuous whatever the input does. With the force bit clear and the external-select bit clear, the input is an envelope that gates the internally divided tone; every burst starts at phase zero, so it opens with a full high half-cycle. With the force bit clear and the external-select bit set, the input already carries a modulated tone and is passed to the output as it is. The input is synchronized by two flops. A hold timer of one tone period is reloaded on each rising edge of the synchronized input, so the tone stays active until about one period after the last rising edge. A low output enable stops everything.

Top module: `tone_mod_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, toneActive and toneOut are 0.
- R2: With outEn=1 and toneForce=1, toneActive is 1 from the first clock edge after toneForce rises. toneOut repeats a 20-cycle pattern of 10 cycles at 1 followed by 10 cycles at 0, and modIn and extSel have no effect.
- R3: With toneForce=0, extSel=0 and outEn=1, toneActive rises on the third clock edge after modIn rises (two synchronizer flops plus one output register). While toneActive is 1, toneOut carries the internal 10-high/10-low tone.
- R4: Each time toneActive rises in internal-tone mode, the divider starts at phase zero, so toneOut is 1 in the first cycle of every burst and stays 1 for 10 cycles.
- R5: With toneForce=0, extSel=1 and outEn=1, toneOut equals modIn delayed by three clock cycles while toneActive is 1.
- R6: In both pin modes, toneActive stays 1 until 20 cycles after the last synchronized rising edge of modIn, or for as long as the synchronized modIn is high, whichever ends later. It then falls to 0 together with toneOut.
- R7: With outEn=0, toneActive and toneOut are 0 from the next clock edge on, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, 20 times the tone frequency |
| rstN | input | 1 | Asynchronous active-low reset |
| outEn | input | 1 | Output enable; 0 means shutdown |
| toneForce | input | 1 | Register bit: continuous internal tone |
| extSel | input | 1 | Register bit: pass modIn through as a modulated tone |
| modIn | input | 1 | External modulation input, asynchronous |
| toneOut | output | 1 | Square-wave tone towards the analog stage |
| toneActive | output | 1 | Tone must be superimposed on the output |

## Verification
A wrong divider phase shows on toneOut in the first cycle of a burst: the output opens low, or the burst's first high half is shorter than 10 cycles. A hold counter that is mis-loaded, or that is not reloaded on later rising edges, shows as toneActive falling too early or too late, or dropping between the pulses of a passed-through tone, within one tone period of the last rising edge. A wrong mode decode shows within three cycles of activation, as toneOut following the internal pattern where it should follow modIn, or the reverse, and the bench compares every cycle of each burst against the pattern that the requirements give.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef struct packed {
    logic phaseClear;
    logic phaseRun;
    logic selExtQ;
    logic activeQ;
  } toneStrobe_t;
endpackage

// File: rtl/tone_ctrl.sv
module tone_ctrl
  import tone_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        outEn,
  input  logic        toneForce,
  input  logic        extSel,
  input  logic        modSync,
  input  logic        holdLive,
  output toneStrobe_t strobe
);
  logic envActive;
  logic extMode;
  logic activeQ;
  logic selExtQ;

  always_comb begin
    envActive = outEn & (toneForce | modSync | holdLive);
    extMode   = ~toneForce & extSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      selExtQ <= 1'b0;
    end else begin
      activeQ <= envActive;
      selExtQ <= extMode;
    end
  end

  always_comb begin
    strobe.phaseClear = ~envActive | ~activeQ;
    strobe.phaseRun   = envActive;
    strobe.selExtQ    = selExtQ;
    strobe.activeQ    = activeQ;
  end

  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |=> !strobe.activeQ); // R7
  AST_FORCE_CONT: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && toneForce) |=> strobe.activeQ); // R2
  AST_HOLD_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && holdLive) |=> strobe.activeQ); // R6
endmodule

// File: rtl/tone_datapath.sv
module tone_datapath
  import tone_pkg::*;
#(
  parameter int DIV         = 20,
  parameter int HOLD        = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modIn,
  input  toneStrobe_t strobe,
  output logic        modSync,
  output logic        holdLive,
  output logic        toneOut
);
  localparam int HALF = DIV / 2;
  localparam int PW   = $clog2(DIV);
  localparam int HW   = $clog2(HOLD + 1);

  logic [SYNC_STAGES:0] syncQ;
  logic                 modRise;
  logic [HW-1:0]        holdCnt;
  logic [PW-1:0]        phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= modIn;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_comb begin
    modSync  = syncQ[SYNC_STAGES-1];
    modRise  = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
    holdLive = (holdCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (modRise)         holdCnt <= HW'(HOLD);
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         phase <= '0;
    else if (strobe.phaseClear)        phase <= '0;
    else if (strobe.phaseRun) begin
      if (phase == PW'(DIV - 1))       phase <= '0;
      else                             phase <= phase + 1'b1;
    end
  end

  always_comb begin
    toneOut = strobe.activeQ &
              (strobe.selExtQ ? syncQ[SYNC_STAGES] : (phase < PW'(HALF)));
  end

  AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    modRise |=> (holdCnt == HW'(HOLD))); // R6
  AST_HOLD_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!modRise && holdCnt != '0) |=> (holdCnt == $past(holdCnt) - 1'b1)); // R6
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.phaseRun && !strobe.phaseClear && phase == PW'(DIV - 1)) |=> (phase == '0)); // R2
endmodule

// File: rtl/tone_mod_ctrl.sv
module tone_mod_ctrl
  import tone_pkg::*;
#(
  parameter int DIV         = 20,
  parameter int HOLD        = DIV,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic outEn,
  input  logic toneForce,
  input  logic extSel,
  input  logic modIn,
  output logic toneOut,
  output logic toneActive
);
  toneStrobe_t strobe;
  logic        modSync;
  logic        holdLive;

  tone_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .outEn     (outEn),
    .toneForce (toneForce),
    .extSel    (extSel),
    .modSync   (modSync),
    .holdLive  (holdLive),
    .strobe    (strobe)
  );

  tone_datapath #(
    .DIV         (DIV),
    .HOLD        (HOLD),
    .SYNC_STAGES (SYNC_STAGES)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .modIn    (modIn),
    .strobe   (strobe),
    .modSync  (modSync),
    .holdLive (holdLive),
    .toneOut  (toneOut)
  );

  assign toneActive = strobe.activeQ;

  AST_BURST_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(toneActive) && !strobe.selExtQ) |-> toneOut); // R4
  AST_IDLE_NO_TONE: assert property (@(posedge clk) disable iff (!rstN)
    !toneActive |-> !toneOut); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!toneActive && !toneOut)); // R1
endmodule

// File: tb/tone_mod_ctrl_test.sv
module tone_mod_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outEn = 1'b0;
  logic toneForce = 1'b0;
  logic extSel = 1'b0;
  logic modIn = 1'b0;
  logic toneOut;
  logic toneActive;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tone_mod_ctrl uut (
    .clk(clk), .rstN(rstN), .outEn(outEn), .toneForce(toneForce),
    .extSel(extSel), .modIn(modIn), .toneOut(toneOut), .toneActive(toneActive)
  );

  task automatic checkBit(input string tag, input string what, input int cyc,
                          input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s cycle %0d: got %0b expected %0b", tag, what, cyc, got, exp);
    end
  endtask

  task automatic idle(input int n);
    toneForce = 1'b0;
    modIn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // R1: reset state
  task automatic testReset();
    @(negedge clk);
    checkBit("R1", "toneActive in reset", 0, toneActive, 1'b0);
    checkBit("R1", "toneOut in reset", 0, toneOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1", "toneActive after reset", 1, toneActive, 1'b0);
    checkBit("R1", "toneOut after reset", 1, toneOut, 1'b0);
  endtask

  function automatic logic pinAt(input bit pass, input int d, input int highLen, input int periods);
    if (d < 0) return 1'b0;
    if (pass) return (d < 20 * periods) && ((d % 20) < 10);
    return d < highLen;
  endfunction

  // R3/R4 envelope mode, R5 pass-through mode, R6 hold window
  task automatic runPin(input bit pass, input int highLen, input int periods);
    int lastAct;
    logic expA, expO;
    outEn = 1'b1;
    toneForce = 1'b0;
    extSel = pass;
    if (pass) lastAct = 20 * (periods - 1) + 23;
    else      lastAct = (highLen + 2 > 23) ? highLen + 2 : 23;
    for (int j = 0; j <= lastAct + 8; j++) begin
      @(negedge clk);
      expA = (j >= 3) && (j <= lastAct);
      if (!expA)      expO = 1'b0;
      else if (pass)  expO = pinAt(1'b1, j - 3, highLen, periods);
      else            expO = ((j - 3) % 20) < 10;
      if (j > lastAct - 3) checkBit("R6", "toneActive hold", j, toneActive, expA);
      else                 checkBit(pass ? "R5" : "R3", "toneActive", j, toneActive, expA);
      if (j == 3 && !pass) checkBit("R4", "burst opens high", j, toneOut, expO);
      else                 checkBit(pass ? "R5" : "R3", "toneOut", j, toneOut, expO);
      modIn = pinAt(pass, j, highLen, periods);
    end
    idle(30);
  endtask

  // R2: forced continuous tone, pin and select ignored
  task automatic testForce();
    outEn = 1'b1;
    for (int j = 0; j <= 45; j++) begin
      @(negedge clk);
      if (j >= 1) begin
        checkBit("R2", "toneActive forced", j, toneActive, 1'b1);
        checkBit("R2", "toneOut forced", j, toneOut, ((j - 1) % 20) < 10);
      end
      if (j == 0) begin
        toneForce = 1'b1;
        extSel = 1'b1;
      end
      modIn = (j % 7) < 3;
    end
    idle(40);
    extSel = 1'b0;
    idle(10);
  endtask

  // R7: shutdown stops tone in forced and envelope modes
  task automatic testShutdown();
    outEn = 1'b1;
    toneForce = 1'b1;
    repeat (15) @(negedge clk);
    checkBit("R7", "active before shutdown", 0, toneActive, 1'b1);
    outEn = 1'b0;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      checkBit("R7", "toneActive shutdown", j, toneActive, 1'b0);
      checkBit("R7", "toneOut shutdown", j, toneOut, 1'b0);
      modIn = (j % 5) < 2;
    end
    toneForce = 1'b0;
    extSel = 1'b0;
    modIn = 1'b1;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      checkBit("R7", "toneActive shutdown envelope", j, toneActive, 1'b0);
      checkBit("R7", "toneOut shutdown envelope", j, toneOut, 1'b0);
    end
    idle(40);
    outEn = 1'b1;
    idle(5);
  endtask

  initial begin
    testReset();
    idle(5);
    runPin(1'b0, 60, 0);
    runPin(1'b0, 7, 0);
    runPin(1'b0, 30, 0);
    runPin(1'b1, 0, 3);
    runPin(1'b1, 0, 1);
    testForce();
    runPin(1'b0, 12, 0);
    testShutdown();
    runPin(1'b1, 0, 2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule